// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Port with Error Flags

This block is an 8-bit SPI port that works either as the clock-driving master or as a clocked slave, chosen by a 4-bit mode field. Software writes a byte to start (master) or preload (slave) a transfer. The byte goes straight into an internal shift register. A separate receive buffer holds the last received byte until software reads it. Data moves MSB first. Each bit is driven when SCK leaves its idle level and sampled when SCK returns to it. The idle level is set by a polarity bit.

The master clock has four sources. Three are fixed divisions of the system clock. The fourth is half the rate of an external timer tick. In slave mode, SCK, SDI and the select input are synchronized to the system clock before use. One slave mode obeys the active-low select and another treats the port as always selected. Two sticky flags report errors. One records a buffer write made while a transfer is in progress. The other records a slave byte that arrived while the buffer was still unread. In that case the new byte is dropped.

Control byte layout: bits [3:0] mode, bit 4 enable, bit 5 polarity, bit 6 write-collision flag, bit 7 overflow flag.

Top module: `spi_port`

## Requirements
- R1: After reset the control byte reads 0, `buf_full` is 0, and `port_en`, `sck_oe` and `sdo_oe` are 0.
- R2: In master mode, SCK half-periods last 2, 8 and 32 system clocks for modes 0000, 0001 and 0010. In mode 0011, SCK toggles once per `tmr_tick` pulse.
- R3: In master mode, a buffer write while idle starts an 8-bit transfer: MSB first, driven on the leaving-idle edge, sampled on the return edge. The received byte then appears on `buf_rd` and `buf_full` goes to 1.
- R4: While no transfer runs, `sck_o` equals the polarity bit (bit 5).
- R5: A buffer write during a transfer sets bit 6 and does not change the byte being sent. Bit 6 stays set until a control write puts 0 in it; writing 1 leaves it set.
- R6: In slave mode, a byte that completes while `buf_full` is 1 sets bit 7 and leaves `buf_rd` unchanged. Bit 7 clears only when a control write puts 0 in it.
- R7: In master mode, bit 7 never sets. A completed byte overwrites the buffer even when it was unread.
- R8: In mode 0100 with `ss_n` high, `sdo_oe` is 0 and the bit counter returns to zero. A byte cut short by `ss_n` does not corrupt the next full byte.
- R9: In mode 0101, `ss_n` is ignored: `sdo_oe` is 1 and transfers complete with `ss_n` high.
- R10: With bit 4 clear, or with any mode code other than 0000 to 0101, `port_en`, `sck_oe` and `sdo_oe` are 0 and buffer writes start nothing.
- R11: A pulse on `buf_re` clears `buf_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wd | input | 8 | Control byte write data |
| ctrl_q | output | 8 | Control byte read value |
| buf_we | input | 1 | Data write strobe |
| buf_wd | input | W | Byte to transmit |
| buf_re | input | 1 | Data read strobe |
| buf_rd | output | W | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| tmr_tick | input | 1 | Timer tick for master mode 0011 |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| sdi | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low slave select |
| port_en | output | 1 | Serial pins owned by the port |

## Verification
A bad bit counter or shift register shows as a wrong byte on `buf_rd` or a wrong bit stream on `sdo`. This appears within the same transfer, at the eighth return edge. A bad divider setting shows as a wrong SCK half-period on the first pulse. A flag that is set or cleared at the wrong time shows on `ctrl_q` in the cycle after the event. A missed overflow shows as `buf_rd` changing when it should have held its old value. A select that is not honoured shows as `sdo_oe` within three clocks of `ss_n` changing.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int W    = 8,
  parameter int DIV0 = 4,
  parameter int DIV1 = 16,
  parameter int DIV2 = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_we,
  input  logic [7:0]   ctrl_wd,
  output logic [7:0]   ctrl_q,
  input  logic         buf_we,
  input  logic [W-1:0] buf_wd,
  input  logic         buf_re,
  output logic [W-1:0] buf_rd,
  output logic         buf_full,
  input  logic         tmr_tick,
  input  logic         sck_i,
  output logic         sck_o,
  output logic         sck_oe,
  output logic         sdo,
  output logic         sdo_oe,
  input  logic         sdi,
  input  logic         ss_n,
  output logic         port_en
);
  localparam int BW   = $clog2(W);
  localparam int DIVW = $clog2(DIV2 / 2);

  logic [3:0] mode;
  logic en, cpol, wcol, ovf;
  logic [2:0] sck_s;
  logic [1:0] ss_s, sdi_s;
  logic [W-1:0] sr;
  logic [BW-1:0] bcnt;
  logic [DIVW-1:0] div, half_m1;
  logic busy, sck_q, out_bit;

  assign ctrl_q = {ovf, wcol, cpol, en, mode};

  wire master = en && mode[3:2] == 2'b00;
  wire slave  = en && (mode == 4'b0100 || mode == 4'b0101);
  wire sel    = slave && (mode[0] || !ss_s[1]);
  wire active = master || sel;
  assign port_en = master || slave;

  always_comb
    case (mode[1:0])
      2'd0:    half_m1 = DIVW'(DIV0 / 2 - 1);
      2'd1:    half_m1 = DIVW'(DIV1 / 2 - 1);
      default: half_m1 = DIVW'(DIV2 / 2 - 1);
    endcase

  wire m_tick  = master && busy && (mode[1:0] == 2'd3 ? tmr_tick : div == half_m1);
  wire s_now   = sck_s[1] ^ cpol;
  wire s_prev  = sck_s[2] ^ cpol;
  wire lead    = master ? (m_tick && !sck_q) : (sel && s_now && !s_prev);
  wire trail   = master ? (m_tick && sck_q)  : (sel && !s_now && s_prev);
  wire done    = trail && bcnt == BW'(W - 1);
  wire [W-1:0] nxt = {sr[W-2:0], master ? sdi : sdi_s[1]};
  wire lose    = slave && buf_full && !buf_re;

  assign sck_o  = cpol ^ sck_q;
  assign sck_oe = master;
  assign sdo    = out_bit;
  assign sdo_oe = master || sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= '0; en <= 1'b0; cpol <= 1'b0; wcol <= 1'b0; ovf <= 1'b0;
      sck_s <= '0; ss_s <= '1; sdi_s <= '0;
      sr <= '0; bcnt <= '0; div <= '0; busy <= 1'b0; sck_q <= 1'b0;
      out_bit <= 1'b0; buf_rd <= '0; buf_full <= 1'b0;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      ss_s  <= {ss_s[0], ss_n};
      sdi_s <= {sdi_s[0], sdi};

      if (ctrl_we) begin
        mode <= ctrl_wd[3:0];
        en   <= ctrl_wd[4];
        cpol <= ctrl_wd[5];
        wcol <= wcol & ctrl_wd[6];
        ovf  <= ovf & ctrl_wd[7];
      end
      if (buf_we && busy) wcol <= 1'b1;
      if (buf_re) buf_full <= 1'b0;

      if (port_en && buf_we && !busy) begin
        sr <= buf_wd;
        if (master) begin
          busy <= 1'b1; div <= '0; sck_q <= 1'b0;
        end
      end
      if (master && busy)
        div <= (div == half_m1) ? '0 : div + DIVW'(1);
      if (lead) begin
        out_bit <= sr[W-1];
        sck_q   <= master;
        busy    <= 1'b1;
      end
      if (trail) begin
        sr    <= nxt;
        bcnt  <= bcnt + BW'(1);
        sck_q <= 1'b0;
      end
      if (done) begin
        bcnt <= '0;
        busy <= 1'b0;
        if (lose) ovf <= 1'b1;
        else begin
          buf_rd   <= nxt;
          buf_full <= 1'b1;
        end
      end
      if (!active) begin
        busy <= 1'b0; bcnt <= '0; sck_q <= 1'b0; div <= '0;
      end
    end
endmodule

module spi_port_chk #(parameter int W = 8) (
  input logic         clk,
  input logic         rst_n,
  input logic         ctrl_we,
  input logic [7:0]   ctrl_q,
  input logic [W-1:0] buf_rd,
  input logic         buf_full,
  input logic         buf_re,
  input logic         sck_o,
  input logic         sck_oe,
  input logic         sdo_oe,
  input logic         port_en,
  input logic         busy,
  input logic         done,
  input logic         slave
);
  assert_ovf_slave_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[7]) |-> $past(slave));
  assert_ovf_keeps_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[7]) |-> $stable(buf_rd));
  assert_off_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !sck_oe && !sdo_oe);
  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && sck_oe |-> sck_o == ctrl_q[5]);
  assert_wcol_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_q[6]) && !$past(ctrl_we) |-> ctrl_q[6]);
  assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    buf_re && !done |=> !buf_full);
endmodule

bind spi_port spi_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_q(ctrl_q), .buf_rd(buf_rd),
  .buf_full(buf_full), .buf_re(buf_re), .sck_o(sck_o), .sck_oe(sck_oe),
  .sdo_oe(sdo_oe), .port_en(port_en), .busy(busy), .done(done), .slave(slave)
);

// File: tb/test_spi_port.sv
module test_spi_port;
  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0, buf_we = 0, buf_re = 0, tmr_tick = 0;
  logic [7:0] ctrl_wd = 0, buf_wd = 0;
  logic sck_i = 0, sdi = 0, ss_n = 1;
  logic [7:0] ctrl_q, buf_rd;
  logic buf_full, sck_o, sck_oe, sdo, sdo_oe, port_en;

  spi_port i_spi_port (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, xfers = 0, nx = 0, last_half = 0;
  bit mst = 1, cpol_b = 0, mon_on = 0, tick_on = 0;
  int tx_q[$], exp_q[$], sdo_q[$];
  string tag_q[$];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic push(int tx, int exp, int so, string tag);
    tx_q.push_back(tx); exp_q.push_back(exp); sdo_q.push_back(so); tag_q.push_back(tag);
  endtask

  task automatic clks(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    mon_on = 0;
    @(posedge clk); #1 ctrl_we = 1; ctrl_wd = v;
    @(posedge clk); #1 ctrl_we = 0;
    cpol_b = v[5];
    clks(4);
    mon_on = 1;
  endtask

  task automatic wr_buf(logic [7:0] v);
    @(posedge clk); #1 buf_we = 1; buf_wd = v;
    @(posedge clk); #1 buf_we = 0;
  endtask

  task automatic rd_buf();
    @(posedge clk); #1 buf_re = 1;
    @(posedge clk); #1 buf_re = 0;
  endtask

  task automatic wait_x();
    nx++;
    wait (xfers == nx);
    clks(4);
  endtask

  task automatic sbyte();
    for (int b = 0; b < 8; b++) begin
      @(posedge clk); #1 sck_i = ~cpol_b;
      clks(8);
      sck_i = cpol_b;
      clks(8);
    end
  endtask

  always @(posedge clk) begin
    int c;
    c = c + 1;
    if (tick_on && c % 5 == 0) tmr_tick <= 1; else tmr_tick <= 0;
  end

  bit pact = 0;
  int bitn = 0, alen = 0, wait_n = 0;
  logic [7:0] cur = 0, got = 0;
  always @(negedge clk) begin
    bit act;
    act = (mst ? sck_o : sck_i) ^ cpol_b;
    if (!mon_on) begin
      bitn = 0; alen = 0;
    end else begin
      if (act && !pact) begin
        if (bitn == 0) cur = tx_q.size() > 0 ? 8'(tx_q.pop_front()) : 8'h00;
        sdi = cur[7 - bitn];
      end
      if (!act && pact) begin
        got = {got[6:0], sdo};
        bitn++;
        if (bitn == 8) begin bitn = 0; wait_n = 6; end
      end
      if (act) alen++;
      else if (pact) begin last_half = alen; alen = 0; end
      if (wait_n > 0) begin
        wait_n--;
        if (wait_n == 0) begin
          int e, s;
          string t;
          e = exp_q.pop_front(); s = sdo_q.pop_front(); t = tag_q.pop_front();
          check(buf_rd == 8'(e), {t, " rx"}, buf_rd, e);
          if (s >= 0) check(got == 8'(s), {t, " tx"}, got, s);
          xfers++;
        end
      end
    end
    pact = act;
  end

  initial begin
    #(4 * 150000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    clks(5);
    rst_n = 1;
    clks(2);
    check(ctrl_q == 8'h00 && buf_full == 0, "R1 ctrl/full", {ctrl_q, 7'b0, buf_full}, 0);
    check(!port_en && !sck_oe && !sdo_oe, "R1 pins", {port_en, sck_oe, sdo_oe}, 0);

    mst = 1;
    wr_ctrl(8'h10);
    push(8'h3C, 8'h3C, 8'hA5, "R3");
    wr_buf(8'hA5); wait_x();
    check(last_half == 2, "R2 div4", last_half, 2);
    check(buf_full == 1, "R3 full", buf_full, 1);
    rd_buf();
    check(buf_full == 0, "R11 read", buf_full, 0);

    wr_ctrl(8'h31);
    check(sck_o == 1, "R4 idle high", sck_o, 1);
    push(8'h5A, 8'h5A, 8'hC3, "R3 cpol1");
    wr_buf(8'hC3); wait_x();
    check(last_half == 8, "R2 div16", last_half, 8);
    check(sck_o == 1, "R4 idle after", sck_o, 1);
    rd_buf();

    wr_ctrl(8'h12);
    check(sck_o == 0, "R4 idle low", sck_o, 0);
    push(8'h81, 8'h81, 8'h7E, "R3 div64");
    wr_buf(8'h7E); wait_x();
    check(last_half == 32, "R2 div64", last_half, 32);

    wr_ctrl(8'h13); tick_on = 1;
    push(8'hE7, 8'hE7, 8'h18, "R7 overwrite/R5 ignored");
    wr_buf(8'h18); clks(12);
    wr_buf(8'hFF); clks(1);
    check(ctrl_q[6] == 1, "R5 set", ctrl_q[6], 1);
    wait_x(); tick_on = 0;
    check(last_half == 5, "R2 timer", last_half, 5);
    check(ctrl_q[7] == 0, "R7 no ovf", ctrl_q[7], 0);
    check(ctrl_q[6] == 1, "R5 sticky", ctrl_q[6], 1);
    wr_ctrl(8'h53);
    check(ctrl_q[6] == 1, "R5 write1", ctrl_q[6], 1);
    wr_ctrl(8'h13);
    check(ctrl_q[6] == 0, "R5 clear", ctrl_q[6], 0);
    rd_buf();

    mst = 0; cpol_b = 0; sck_i = 0;
    wr_ctrl(8'h14);
    clks(4);
    check(sdo_oe == 0 && sck_oe == 0, "R8 deselected", {sdo_oe, sck_oe}, 0);
    ss_n = 0; clks(4);
    check(sdo_oe == 1, "R8 selected", sdo_oe, 1);
    wr_buf(8'h96);
    push(8'h69, 8'h69, 8'h96, "R8 slave");
    sbyte(); wait_x();
    push(8'h11, 8'h69, -1, "R6 kept");
    sbyte(); wait_x();
    check(ctrl_q[7] == 1 && buf_full == 1, "R6 ovf", {ctrl_q[7], buf_full}, 2'b11);
    wr_ctrl(8'hD4);
    check(ctrl_q[7] == 1, "R6 write1", ctrl_q[7], 1);
    wr_ctrl(8'h14);
    check(ctrl_q[7] == 0, "R6 clear", ctrl_q[7], 0);
    rd_buf();

    mon_on = 0;
    for (int b = 0; b < 3; b++) begin
      sck_i = 1; clks(8); sck_i = 0; clks(8);
    end
    ss_n = 1; clks(4);
    check(sdo_oe == 0, "R8 ss high", sdo_oe, 0);
    ss_n = 0; clks(4); mon_on = 1;
    push(8'h4D, 8'h4D, -1, "R8 restart");
    sbyte(); wait_x();
    rd_buf();

    wr_ctrl(8'h15);
    ss_n = 1; clks(4);
    check(sdo_oe == 1, "R9 no select", sdo_oe, 1);
    wr_buf(8'h2B);
    push(8'hD4, 8'hD4, 8'h2B, "R9 xfer");
    sbyte(); wait_x();
    rd_buf();

    mst = 1;
    wr_ctrl(8'h16);
    check(!port_en && !sdo_oe && !sck_oe, "R10 reserved", {port_en, sdo_oe, sck_oe}, 0);
    wr_ctrl(8'h18);
    check(!port_en, "R10 reserved hi", port_en, 0);
    wr_ctrl(8'h00);
    wr_buf(8'h55); clks(40);
    check(!port_en && !sck_oe && !buf_full, "R10 disabled", {port_en, sck_oe, buf_full}, 0);
    check(xfers == nx, "R10 no xfer", xfers, nx);
    finish_run();
  end
endmodule